// File: doc/BRIEF.md
# Interlaced Luma Capture and Field Weaver

This block takes a digital component video byte stream, one byte per accepted clock, and turns the two interlaced fields of each frame into one progressive luma image in an external frame buffer. It finds the embedded four-byte timing codes in the stream and reads the field, vertical-blank and horizontal-blank flags from each one. From that it tracks which field is arriving and which active line of that field is in progress.

Inside an active segment the samples alternate chroma and luma. Only the luma bytes are passed on, as single-byte writes to a plain write port (enable, linear address, data). The lines of the first field land on even frame rows and the lines of the second field on odd rows, so the buffer holds a woven progressive frame. A one-clock done pulse marks the moment both fields of a frame have been stored.

The input follows valid/ready rules. `in_ready` goes high on the first clock after reset and stays high, so a byte is taken on every clock where `in_valid` is high. The source may drop `in_valid` on any clock, including in the middle of a timing code. A low `in_valid` clock is not a sample. The write port has no back-pressure: the frame buffer must accept one write on any clock.

Top module: `luma_weave_capture`

## Requirements
- R1: From the first clock after reset `in_ready` is 1. While in reset and until the first stream byte, `wr_en` and `frame_done` are 0.
- R2: A timing code is the accepted byte run 0xFF, 0x00, 0x00, S where S bit 7 is 1. S bit 6 is the field flag F, bit 5 the vertical-blank flag V and bit 4 the horizontal-blank flag H. A broken run (for example 0xFF, 0x00, then a non-zero byte) is not a code.
- R3: After a code with H=0 and V=0 (start of active video) the bytes run chroma, luma, chroma, luma. Only the second, fourth, ... bytes are written, at columns 0, 1, 2, ..., and the column restarts at 0 on every such code.
- R4: After a start code with V=1, no byte is written until the next start code with V=0.
- R5: The line index of a field is 0 for the first active line after a code with V=1, and it rises by one at each end code (H=1, V=0) that closes an active line. Luma at column c of line k in field F goes to address (2k+F)*PIX + c.
- R6: Clocks with `in_valid` low are ignored: they neither advance the column nor break a timing code.
- R7: Luma at column PIX or beyond, or on line LINES or beyond, is not written, so `wr_addr` stays below 2*LINES*PIX.
- R8: A luma position that carries a reserved value 0x00 or 0xFF is never written. This covers the preamble of an end code that arrives early.
- R9: `frame_done` is a one-clock pulse on the clock after the end code that closes line LINES-1 of field 1. It is raised only if line LINES-1 of field 0 was closed since the previous pulse.
- R10: A write appears on the write port on the clock right after its luma byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte (always high after reset) |
| wr_en | output | 1 | Frame-buffer write strobe |
| wr_addr | output | ADDR_W | Linear frame-buffer address, row*PIX + column |
| wr_data | output | 8 | Luma value to store |
| frame_done | output | 1 | One-clock pulse when both fields of a frame are stored |

## Verification
On every clock the embedded assertions check that:
- `in_ready` holds high after reset;
- a write only follows an accepted byte;
- no write carries a reserved value or leaves the frame area;
- the field line counter never passes LINES;
- the done pulse never lasts two clocks.

Only the bench's scenarios can show the woven placement of every luma sample, the rejection of broken code runs and blank-line data, and the clipping of short and long lines. The same holds for the exact clock of the done pulse and its suppression when a second field arrives without a first.

// File: rtl/capture_pkg.sv
package capture_pkg;

  typedef struct packed {
    logic fld;
    logic vblank;
    logic hblank;
  } code_flags_t;

  typedef enum logic [1:0] {
    SY_IDLE = 2'd0,
    SY_FF   = 2'd1,
    SY_Z1   = 2'd2,
    SY_Z2   = 2'd3
  } sync_state_e;

  function automatic logic is_reserved(input logic [7:0] b);
    return (b == 8'h00) || (b == 8'hFF);
  endfunction

endpackage

// File: rtl/sync_code_finder.sv
module sync_code_finder
  import capture_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        code_stb,
  output code_flags_t code_flags
);

  sync_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SY_IDLE;
    end else if (in_valid) begin
      unique case (st)
        SY_IDLE: st <= (in_data == 8'hFF) ? SY_FF : SY_IDLE;
        SY_FF: begin
          if (in_data == 8'h00)      st <= SY_Z1;
          else if (in_data == 8'hFF) st <= SY_FF;
          else                       st <= SY_IDLE;
        end
        SY_Z1: begin
          if (in_data == 8'h00)      st <= SY_Z2;
          else if (in_data == 8'hFF) st <= SY_FF;
          else                       st <= SY_IDLE;
        end
        SY_Z2:   st <= SY_IDLE;
        default: st <= SY_IDLE;
      endcase
    end
  end

  // status byte sits in the fourth accepted position of the run
  assign code_stb          = in_valid && (st == SY_Z2) && in_data[7];
  assign code_flags.fld    = in_data[6];
  assign code_flags.vblank = in_data[5];
  assign code_flags.hblank = in_data[4];

endmodule

// File: rtl/field_line_tracker.sv
module field_line_tracker
  import capture_pkg::*;
#(
  parameter int LINES = 240,
  localparam int LW = $clog2(LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          code_stb,
  input  code_flags_t   code_flags,
  output logic          active,
  output logic          field,
  output logic [LW-1:0] line_idx,
  output logic          sav_stb,
  output logic          frame_done
);

  localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);
  localparam logic [LW-1:0] LINE_CAP  = LW'(LINES);

  logic first_stored;
  logic eav_stb;

  assign sav_stb = code_stb && !code_flags.vblank && !code_flags.hblank;
  assign eav_stb = code_stb && !code_flags.vblank && code_flags.hblank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      field        <= 1'b0;
      line_idx     <= '0;
      first_stored <= 1'b0;
      frame_done   <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (code_stb && code_flags.vblank) begin
        active   <= 1'b0;
        line_idx <= '0;
      end else if (sav_stb) begin
        active <= 1'b1;
        field  <= code_flags.fld;
      end else if (eav_stb && active) begin
        active <= 1'b0;
        if (line_idx != LINE_CAP) line_idx <= line_idx + 1'b1;
        if (line_idx == LAST_LINE) begin
          if (!field) begin
            first_stored <= 1'b1;
          end else if (first_stored) begin
            frame_done   <= 1'b1;
            first_stored <= 1'b0;
          end
        end
      end
    end
  end

  p_line_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_idx <= LINE_CAP);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

// File: rtl/luma_row_writer.sv
module luma_row_writer
  import capture_pkg::*;
#(
  parameter int PIX   = 720,
  parameter int LINES = 240,
  localparam int LW     = $clog2(LINES + 1),
  localparam int CW     = $clog2(PIX + 1),
  localparam int ADDR_W = $clog2(2 * LINES * PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              code_stb,
  input  logic              sav_stb,
  input  logic              active,
  input  logic              field,
  input  logic [LW-1:0]     line_idx,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  localparam logic [CW-1:0]     PIX_C   = CW'(PIX);
  localparam logic [LW-1:0]     LINES_L = LW'(LINES);
  localparam logic [ADDR_W-1:0] PIX_A   = ADDR_W'(PIX);
  localparam int                FRAME   = 2 * LINES * PIX;

  logic              luma_phase;
  logic [CW-1:0]     col;
  logic              sample_stb;
  logic              take;
  logic [ADDR_W-1:0] row_a;
  logic [ADDR_W-1:0] addr_n;

  assign sample_stb = in_valid && active && !code_stb;

  always_comb begin
    take   = sample_stb && luma_phase && (col < PIX_C) && (line_idx < LINES_L)
             && !is_reserved(in_data);
    row_a  = ADDR_W'({line_idx, field});
    addr_n = row_a * PIX_A + ADDR_W'(col);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_phase <= 1'b0;
      col        <= '0;
    end else if (sav_stb) begin
      luma_phase <= 1'b0;
      col        <= '0;
    end else if (sample_stb) begin
      luma_phase <= !luma_phase;
      if (luma_phase && col != PIX_C) col <= col + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= take;
      if (take) begin
        wr_addr <= addr_n;
        wr_data <= in_data;
      end
    end
  end

  p_addr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < FRAME));

  p_no_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data != 8'h00 && wr_data != 8'hFF));

  p_write_follows_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid));

endmodule

// File: rtl/luma_weave_capture.sv
module luma_weave_capture
  import capture_pkg::*;
#(
  parameter int PIX   = 720,
  parameter int LINES = 240,
  localparam int ADDR_W = $clog2(2 * LINES * PIX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              frame_done
);

  localparam int LW = $clog2(LINES + 1);

  logic          code_stb;
  code_flags_t   code_flags;
  logic          active;
  logic          field;
  logic [LW-1:0] line_idx;
  logic          sav_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  sync_code_finder u_finder (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .code_stb   (code_stb),
    .code_flags (code_flags)
  );

  field_line_tracker #(.LINES(LINES)) u_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_stb   (code_stb),
    .code_flags (code_flags),
    .active     (active),
    .field      (field),
    .line_idx   (line_idx),
    .sav_stb    (sav_stb),
    .frame_done (frame_done)
  );

  luma_row_writer #(.PIX(PIX), .LINES(LINES)) u_writer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .code_stb (code_stb),
    .sav_stb  (sav_stb),
    .active   (active),
    .field    (field),
    .line_idx (line_idx),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

endmodule

// File: tb/luma_weave_capture_test.sv
module luma_weave_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int PIX   = 4;
  localparam int LINES = 3;
  localparam int FRAME = 2 * LINES * PIX;
  localparam int AW    = $clog2(FRAME);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          frame_done;

  int checks = 0;
  int errors = 0;
  int nbytes = 0;
  int wr_cnt = 0;
  int done_cnt = 0;
  int done_at = -1;
  int exp_done_at = -2;
  int bad_addr = 0;
  int cycles = 0;
  logic [7:0] shadow [FRAME];

  always #(CLK_PERIOD / 2) clk = ~clk;

  luma_weave_capture #(.PIX(PIX), .LINES(LINES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] yv(input int f, input int l, input int c);
    return 8'(20 + ((f * LINES + l) * PIX + c) * 9);
  endfunction

  function automatic logic [7:0] yp(input int l, input int c);
    return 8'(60 + l * 50 + c * 7);
  endfunction

  task automatic sample();
    if (wr_en) begin
      if (int'(wr_addr) < FRAME) shadow[int'(wr_addr)] = wr_data;
      else bad_addr++;
      wr_cnt++;
    end
    if (frame_done) begin
      done_cnt++;
      done_at = nbytes;
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    sample();
    in_valid = 1'b1;
    in_data  = b;
    nbytes++;
  endtask

  task automatic gap();
    @(negedge clk);
    sample();
    in_valid = 1'b0;
    in_data  = 8'hFF;
  endtask

  task automatic code(input bit f, input bit v, input bit h);
    put(8'hFF); put(8'h00); put(8'h00);
    put({1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h});
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) put((i % 2 == 0) ? 8'h80 : 8'h10);
  endtask

  task automatic vblank(input bit f);
    code(f, 1'b1, 1'b1);
    blank(3);
    code(f, 1'b1, 1'b0);   // start code inside vertical blank: data must be dropped
    put(8'h80); put(8'h55); put(8'h80); put(8'h66);
    code(f, 1'b1, 1'b1);
    blank(2);
  endtask

  task automatic frame_line(input bit f, input int l, input bit gaps);
    code(f, 1'b0, 1'b0);
    for (int c = 0; c < PIX; c++) begin
      put(8'h80);
      if (gaps) gap();
      put(yv(f, l, c));
      if (gaps && c % 2 == 1) begin gap(); gap(); end
    end
    code(f, 1'b0, 1'b1);
    if (f && l == LINES - 1) exp_done_at = nbytes;
    blank(4);
  endtask

  task automatic clear_shadow();
    for (int i = 0; i < FRAME; i++) shadow[i] = 8'h00;
    wr_cnt = 0;
  endtask

  initial begin
    int base;
    clear_shadow();
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R1 wr_en in reset", wr_en, 0);
    chk(frame_done == 1'b0, "R1 frame_done in reset", frame_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(wr_en == 1'b0, "R1 idle after reset", wr_en, 0);

    // Part 1: broken code run, blank-line data, short and long lines in field 1
    vblank(1'b1);
    put(8'hFF); put(8'h00); put(8'h12); put(8'h80);
    put(8'h80); put(8'h44); put(8'h80); put(8'h45);
    gap(); gap();
    chk(wr_cnt == 0, "R2/R4 no write from broken code or blank line", wr_cnt, 0);

    code(1'b1, 1'b0, 1'b0);              // line 0: only two samples, then early end code
    for (int c = 0; c < 2; c++) begin put(8'h80); put(yp(0, c)); end
    code(1'b1, 1'b0, 1'b1);
    blank(4);
    code(1'b1, 1'b0, 1'b0);              // line 1: PIX+2 samples
    for (int c = 0; c < PIX + 2; c++) begin put(8'h80); put(yp(1, c)); end
    code(1'b1, 1'b0, 1'b1);
    blank(4);
    gap(); gap();
    chk(wr_cnt == 2 + PIX, "R7/R8 write count for short and long lines", wr_cnt, 2 + PIX);
    chk(bad_addr == 0, "R7 address range", bad_addr, 0);
    for (int c = 0; c < 2; c++)
      chk(shadow[1 * PIX + c] == yp(0, c), "R3/R5 short line value", shadow[1 * PIX + c], yp(0, c));
    chk(shadow[1 * PIX + 2] == 8'h00, "R8 reserved byte not stored", shadow[1 * PIX + 2], 0);
    for (int c = 0; c < PIX; c++)
      chk(shadow[3 * PIX + c] == yp(1, c), "R3/R7 long line clipped", shadow[3 * PIX + c], yp(1, c));
    chk(done_cnt == 0, "R9 no done without full frame", done_cnt, 0);

    // Part 2: full woven frame, field 1 with idle clocks
    clear_shadow();
    vblank(1'b0);
    for (int l = 0; l < LINES; l++) frame_line(1'b0, l, 1'b0);
    vblank(1'b1);
    for (int l = 0; l < LINES; l++) frame_line(1'b1, l, 1'b1);
    gap(); gap();
    chk(done_cnt == 1, "R9 one done pulse per frame", done_cnt, 1);
    chk(done_at == exp_done_at, "R9 done on clock after closing end code", done_at, exp_done_at);
    chk(wr_cnt == FRAME, "R5/R6 write count for full frame", wr_cnt, FRAME);
    for (int row = 0; row < 2 * LINES; row++)
      for (int c = 0; c < PIX; c++) begin
        base = row * PIX + c;
        chk(shadow[base] == yv(row % 2, row / 2, c), "R3/R5/R6 woven luma",
            shadow[base], yv(row % 2, row / 2, c));
      end

    // Part 3: field 1 alone plus one extra line: no done, extra line dropped
    wr_cnt = 0;
    vblank(1'b1);
    for (int l = 0; l <= LINES; l++) frame_line(1'b1, l, 1'b0);
    gap(); gap();
    chk(done_cnt == 1, "R9 second field alone gives no done", done_cnt, 1);
    chk(wr_cnt == LINES * PIX, "R7 line beyond LINES not written", wr_cnt, LINES * PIX);
    chk(bad_addr == 0, "R7 address range after extra line", bad_addr, 0);

    // Part 4: write latency
    vblank(1'b0);
    code(1'b0, 1'b0, 1'b0);
    put(8'h80);
    put(8'h77);
    gap();
    chk(wr_en == 1'b1, "R10 write on next clock", wr_en, 1);
    chk(wr_data == 8'h77, "R10 write data", wr_data, 8'h77);
    chk(wr_addr == '0, "R10/R5 write address", int'(wr_addr), 0);
    gap();
    chk(wr_en == 1'b0, "R6 no write while idle", wr_en, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule